// File: doc/BRIEF.md
# Inhibitable Parallel/Serial-In, Serial-Out Shift Register

This block is an eight-stage register that turns a broadside word into a bit stream. On each rising edge of the single system clock it either captures a whole word from the parallel bus or moves its contents one stage toward the last stage, taking a new bit from the serial input into the first stage. Only the last stage drives the serial output. A debug view of every stage is also brought out.

An active-high hold input freezes the register on any edge where it is sampled high. This lets the system clock run freely while the consumer of the stream stops the register on command. An asynchronous active-low clear empties every stage at once, whatever the clock, the hold or the mode select are doing.

Top module: `piso_shift_reg`

## Requirements
- R1: The register has `WIDTH` stages (default 8). Bit i of `stages_o` is stage i: bit 0 is the first stage and bit `WIDTH-1` is the last. `ser_o` always equals the last stage.
- R2: While `rst_n` is low, every stage is zero. This takes effect at once, with no clock edge, and overrides `hold_i`, `shift_sel_i` and the clock.
- R3: On a rising edge with `hold_i` = 0 and `shift_sel_i` = 1, stage 0 takes `ser_i` and each stage i > 0 takes the old value of stage i-1.
- R4: On a rising edge with `hold_i` = 0 and `shift_sel_i` = 0, stage i takes `par_i[i]` for every i. `ser_i` has no effect on that edge.
- R5: On a rising edge with `hold_i` = 1, every stage keeps its value, whatever `shift_sel_i`, `ser_i` and `par_i` are.
- R6: The first rising edge after `rst_n` goes high acts on all-zero contents.
- R7: After a load, `ser_o` shows `par_i[WIDTH-1]`. Each later shift edge then shows the next lower loaded bit, down to `par_i[0]`, and after that the bits that entered through `ser_i`, in the order they entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous clear, active low |
| hold_i | input | 1 | Freezes all stages when high at an edge |
| shift_sel_i | input | 1 | 1 = shift toward last stage, 0 = parallel load |
| ser_i | input | 1 | Serial bit entering stage 0 on a shift |
| par_i | input | WIDTH | Broadside word; bit i goes to stage i on a load |
| ser_o | output | 1 | Serial output, the last stage |
| stages_o | output | WIDTH | Debug view of all stages, bit i = stage i |

## Verification
The assertions assume that `hold_i`, `shift_sel_i`, `ser_i` and `par_i` change only between clock edges, and that `rst_n` is released away from a rising edge. The single-edge properties can then compare each edge's result with the inputs sampled at that edge. The stimulus honours this by changing every input on the falling clock edge. It also drops `rst_n` in the middle of a clock phase to show that the clear does not wait for an edge, and it always releases the clear well clear of a rising edge.

// File: rtl/piso_pkg.sv
package piso_pkg;

    // Action taken by the stages on a rising clock edge
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } piso_op_e;

endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl
    import piso_pkg::*;
(
    input  logic     hold_i,
    input  logic     shift_sel_i,
    output piso_op_e op_o
);

    // Hold has priority over both data paths
    always_comb begin
        if (hold_i)
            op_o = OP_HOLD;
        else if (shift_sel_i)
            op_o = OP_SHIFT;
        else
            op_o = OP_LOAD;
    end

endmodule

// File: rtl/piso_stages.sv
module piso_stages
    import piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  piso_op_e         op_i,
    input  logic             ser_i,
    input  logic [WIDTH-1:0] par_i,
    output logic [WIDTH-1:0] q_o
);

    localparam int LAST = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op_i)
            OP_SHIFT: st_d.bits = {st_q.bits[LAST-1:0], ser_i};
            OP_LOAD:  st_d.bits = par_i;
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign q_o = st_q.bits;

endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
    import piso_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             shift_sel_i,
    input  logic             ser_i,
    input  logic [WIDTH-1:0] par_i,
    output logic             ser_o,
    output logic [WIDTH-1:0] stages_o
);

    localparam int LAST = WIDTH - 1;

    piso_op_e op;

    piso_ctrl u_ctrl (
        .hold_i      (hold_i),
        .shift_sel_i (shift_sel_i),
        .op_o        (op)
    );

    piso_stages #(.WIDTH(WIDTH)) u_stages (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (op),
        .ser_i (ser_i),
        .par_i (par_i),
        .q_o   (stages_o)
    );

    // R1: the serial output is the last stage
    assign ser_o = stages_o[LAST];

    // R6: contents seen by the first edge after clear release are zero
    assert_release_zero_R6: assert property (@(posedge clk)
        $rose(rst_n) |-> (stages_o == '0));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(stages_o));

    assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && shift_sel_i) |=>
            (stages_o == {$past(stages_o[LAST-1:0]), $past(ser_i)}));

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !shift_sel_i) |=> (stages_o == $past(par_i)));

endmodule

// File: tb/piso_shift_reg_tb.sv
module piso_shift_reg_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         hold_i = 1'b0;
    logic         shift_sel_i = 1'b0;
    logic         ser_i = 1'b0;
    logic [W-1:0] par_i = '0;
    logic         ser_o;
    logic [W-1:0] stages_o;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] model = '0;

    always #10 clk = ~clk;

    piso_shift_reg #(.WIDTH(W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_i      (hold_i),
        .shift_sel_i (shift_sel_i),
        .ser_i       (ser_i),
        .par_i       (par_i),
        .ser_o       (ser_o),
        .stages_o    (stages_o)
    );

    function automatic logic [W-1:0] next_val(input logic [W-1:0] cur,
            input logic h, input logic s, input logic d, input logic [W-1:0] p);
        if (h)      return cur;
        else if (s) return {cur[W-2:0], d};
        else        return p;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive inputs after a falling edge, clock once, compare at next falling edge
    task automatic step(input string req, input logic h, input logic s,
                        input logic d, input logic [W-1:0] p);
        hold_i = h; shift_sel_i = s; ser_i = d; par_i = p;
        @(posedge clk);
        model = next_val(model, h, s, d, p);
        @(negedge clk);
        check(req, stages_o, model);
        check({req, " R1 ser_o"}, {{(W-1){1'b0}}, ser_o}, {{(W-1){1'b0}}, model[W-1]});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [W-1:0] word;
        void'($urandom(32'd4242));
        repeat (2) @(negedge clk);
        check("R2 reset", stages_o, '0);
        #5 rst_n = 1'b1;
        @(negedge clk);

        // R6: first edge after release shifts a one into zero contents
        step("R6", 1'b0, 1'b1, 1'b1, '0);
        check("R6 exact", stages_o, 8'h01);

        // R4: load with serial input high, ignored
        step("R4", 1'b0, 1'b0, 1'b1, 8'hA5);
        check("R4 ser ignored", stages_o, 8'hA5);

        // R5: inhibited edges in both modes hold contents
        step("R5 load", 1'b1, 1'b0, 1'b0, 8'h3C);
        step("R5 shift", 1'b1, 1'b1, 1'b1, 8'hFF);
        check("R5 held", stages_o, 8'hA5);

        // R2: clear mid-phase, no edge needed, overrides hold
        hold_i = 1'b1;
        #3 rst_n = 1'b0;
        #2 check("R2 async", stages_o, '0);
        model = '0;
        @(negedge clk);
        check("R2 held low", stages_o, '0);
        #5 rst_n = 1'b1;
        @(negedge clk);

        // R5 then R7: inhibited edge, load, eight shifts of ones
        step("R5 after clear", 1'b1, 1'b0, 1'b0, 8'hFF);
        check("R5 cleared held", stages_o, '0);
        word = 8'b1001_0110;
        step("R4 load seq", 1'b0, 1'b0, 1'b0, word);
        check("R7 first bit", {7'd0, ser_o}, {7'd0, word[W-1]});
        for (int i = 1; i <= W; i++) begin
            step("R3 seq", 1'b0, 1'b1, 1'b1, 8'h00);
            if (i < W)
                check("R7 order", {7'd0, ser_o}, {7'd0, word[W-1-i]});
            else
                check("R7 serial", {7'd0, ser_o}, 8'h01);
        end
        check("R3 all ones", stages_o, 8'hFF);

        // Random mix against the model
        for (int n = 0; n < 300; n++) begin
            logic h;
            h = ($urandom % 4) == 0;
            step("R3/R4/R5 rand", h, 1'($urandom), 1'($urandom), 8'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule